// File: doc/BRIEF.md
# Keypad Combination Lock Detector

This block watches a numeric keypad and raises an unlock pulse when the user enters a fixed secret sequence: the start key, then four code digits, then the open key. The keypad front end delivers ten digit lines, a start line and an open line, with at most one of them high at a time. It also delivers an any-button line that is high while any key is held. The detector takes one key event on each rising edge of the any-button line. A held key therefore counts once, and so does a key whose line takes over while the any-button line stays high.

The four code digits are elaboration-time parameters. The sequence must be contiguous. A start press begins a fresh attempt from any point. A wrong digit, an open press in the wrong place, or a fifth digit throws the attempt away. After a correct open press the unlock output is high for exactly one clock cycle and the machine returns to idle. The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `combo_lock_detector`

## Requirements
- R1: While reset is held, and after it is released, unlock_o is low. The machine starts idle, so digits followed by open with no start key never unlock.
- R2: A key is taken only in the cycle where any_i goes from low to high. Holding a key for many cycles counts it once. A key line that changes while any_i stays high is not taken.
- R3: Start, then CODE0, CODE1, CODE2, CODE3 in that order, then open, raises unlock_o for exactly one cycle. That cycle follows the clock edge at which the open press is taken.
- R4: A digit that differs from the expected code digit ends the attempt. Later correct digits and open, with no new start, do not unlock.
- R5: An open press anywhere other than directly after the fourth correct digit ends the attempt without unlocking.
- R6: A fifth digit after four correct digits ends the attempt, so a following open press does not unlock.
- R7: A start press in any state begins a new attempt that expects CODE0 next. A partial attempt before it has no effect on the result.
- R8: A digit press while idle leaves the machine idle.
- R9: A rising any_i with no key line asserted is ignored. An attempt in progress continues as if it had not occurred.
- R10: digit_i bit n stands for digit n (0 to 9). Start takes precedence over open, and open over digits, if several lines are seen together. Each code parameter is a 4-bit value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| digit_i | input | 10 | One line per digit key; bit n is digit n |
| start_i | input | 1 | Start key line |
| open_i | input | 1 | Open key line |
| any_i | input | 1 | High while any key is held |
| unlock_o | output | 1 | One-cycle pulse after a correct sequence |

## Verification
On every cycle the assertions check the following:
- unlock_o never stays high for two cycles;
- each unlock is preceded by an open event taken in the fourth-digit state;
- a start event always leads to the armed state;
- a mismatching first digit leads to idle;
- the state never moves without an event;
- no event is taken while any_i was already high.

Other properties need the bench's key sequences against its reference model:
- the whole-sequence outcome (exactly which sequences unlock);
- that a held key or a key line switched under a high any_i counts once;
- that an empty press leaves an attempt intact;
- that a restart discards a partial attempt.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_D1,
    ST_D2,
    ST_D3,
    ST_D4,
    ST_OPEN
  } lock_state_t;

  typedef enum logic [1:0] {
    KEY_NONE,
    KEY_DIGIT,
    KEY_START,
    KEY_OPEN
  } key_kind_t;

  typedef struct packed {
    logic               valid;
    key_kind_t          kind;
    logic [DIGIT_W-1:0] digit;
  } key_evt_t;
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lock_key_capture.sv
module lock_key_capture
  import combo_lock_pkg::*;
#(
  parameter int NUM_DIGITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIGITS-1:0] digit_i,
  input  logic                  start_i,
  input  logic                  open_i,
  input  logic                  any_i,
  output key_evt_t              evt_o
);
  logic               any_q;
  logic               press;
  logic [DIGIT_W-1:0] enc;
  key_kind_t          kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_i;
  end

  assign press = any_i & ~any_q;

  always_comb begin
    enc = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (digit_i[i]) enc = DIGIT_W'(i);
    end
  end

  always_comb begin
    if (start_i)       kind = KEY_START;
    else if (open_i)   kind = KEY_OPEN;
    else if (|digit_i) kind = KEY_DIGIT;
    else               kind = KEY_NONE;
  end

  always_comb begin
    evt_o.valid = press && (kind != KEY_NONE);
    evt_o.kind  = kind;
    evt_o.digit = enc;
  end

  // R2: no event while the any-button line was already high
  a_r2_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_i) && any_i) |-> !evt_o.valid);
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import combo_lock_pkg::*;
#(
  parameter logic [DIGIT_W-1:0] CODE0 = 4'd4,
  parameter logic [DIGIT_W-1:0] CODE1 = 4'd7,
  parameter logic [DIGIT_W-1:0] CODE2 = 4'd1,
  parameter logic [DIGIT_W-1:0] CODE3 = 4'd9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  key_evt_t evt_i,
  output logic     unlock_o
);
  lock_state_t        state_q, state_d;
  logic [DIGIT_W-1:0] want;
  logic               unlock_q;
  lock_state_t        digit_next;

  always_comb begin
    unique case (state_q)
      ST_ARMED: begin want = CODE0; digit_next = ST_D1; end
      ST_D1:    begin want = CODE1; digit_next = ST_D2; end
      ST_D2:    begin want = CODE2; digit_next = ST_D3; end
      ST_D3:    begin want = CODE3; digit_next = ST_D4; end
      default:  begin want = '0;    digit_next = ST_IDLE; end
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == ST_OPEN) state_d = ST_IDLE;
    if (evt_i.valid) begin
      unique case (evt_i.kind)
        KEY_START: state_d = ST_ARMED;
        KEY_OPEN:  state_d = (state_q == ST_D4) ? ST_OPEN : ST_IDLE;
        KEY_DIGIT: begin
          if (digit_next != ST_IDLE && evt_i.digit == want) state_d = digit_next;
          else                                              state_d = ST_IDLE;
        end
        default:   state_d = state_d;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      unlock_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      unlock_q <= (state_d == ST_OPEN);
    end
  end

  assign unlock_o = unlock_q;

  // R3: the pulse lasts one cycle
  a_r3_unlock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_q |=> !unlock_q);
  // R5: unlock only from an open event in the fourth-digit state
  a_r5_unlock_after_open: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_q |-> $past(evt_i.valid && evt_i.kind == KEY_OPEN && state_q == ST_D4));
  // R7: start always re-arms
  a_r7_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.valid && evt_i.kind == KEY_START) |=> (state_q == ST_ARMED));
  // R4: wrong first digit goes idle
  a_r4_wrong_first: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.valid && evt_i.kind == KEY_DIGIT && state_q == ST_ARMED && evt_i.digit != CODE0)
      |=> (state_q == ST_IDLE));
  // R9: no event, no move (except leaving the unlock state)
  a_r9_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.valid && state_q != ST_OPEN) |=> $stable(state_q));
endmodule

// File: rtl/combo_lock_detector.sv
module combo_lock_detector
  import combo_lock_pkg::*;
#(
  parameter int                 NUM_DIGITS = 10,
  parameter logic [DIGIT_W-1:0] CODE0      = 4'd4,
  parameter logic [DIGIT_W-1:0] CODE1      = 4'd7,
  parameter logic [DIGIT_W-1:0] CODE2      = 4'd1,
  parameter logic [DIGIT_W-1:0] CODE3      = 4'd9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DIGITS-1:0] digit_i,
  input  logic                  start_i,
  input  logic                  open_i,
  input  logic                  any_i,
  output logic                  unlock_o
);
  logic     rst_n_sync;
  key_evt_t evt;

  lock_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lock_key_capture #(.NUM_DIGITS(NUM_DIGITS)) u_keys (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .digit_i (digit_i),
    .start_i (start_i),
    .open_i  (open_i),
    .any_i   (any_i),
    .evt_o   (evt)
  );

  lock_seq_fsm #(
    .CODE0(CODE0), .CODE1(CODE1), .CODE2(CODE2), .CODE3(CODE3)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .evt_i    (evt),
    .unlock_o (unlock_o)
  );
endmodule

// File: tb/test_combo_lock_detector.sv
`timescale 1ns/1ps
module test_combo_lock_detector;
  localparam int C0 = 4, C1 = 7, C2 = 1, C3 = 9;
  localparam int K_NONE = 0, K_DIG = 1, K_START = 2, K_OPEN = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] digit_i;
  logic       start_i, open_i, any_i;
  logic       unlock_o;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  combo_lock_detector i_combo_lock_detector (
    .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .start_i(start_i),
    .open_i(open_i), .any_i(any_i), .unlock_o(unlock_o)
  );

  function automatic int code_at(int i);
    case (i)
      0: return C0;
      1: return C1;
      2: return C2;
      default: return C3;
    endcase
  endfunction

  // progress: 0 idle, 1 after start, 2..5 digits matched, 6 unlocked
  function automatic int model_next(int p, int kind, int dig);
    if (kind == K_NONE)  return p;
    if (kind == K_START) return 1;
    if (kind == K_OPEN)  return (p == 5) ? 6 : 0;
    if (p >= 1 && p <= 4 && dig == code_at(p - 1)) return p + 1;
    return 0;
  endfunction

  task automatic check(logic exp, string req);
    checks++;
    if (unlock_o !== exp) begin
      errors++;
      $display("FAIL %s: unlock_o=%b expected %b", req, unlock_o, exp);
    end
  endtask

  // drive one key press; hold >= 1 cycle, gap >= 1 cycle
  task automatic press(int kind, int dig, int hold, int gap, string req);
    @(negedge clk);
    digit_i = '0; start_i = 0; open_i = 0;
    if (kind == K_DIG)   digit_i[dig] = 1'b1;
    if (kind == K_START) start_i = 1'b1;
    if (kind == K_OPEN)  open_i = 1'b1;
    any_i = 1'b1;
    pos = model_next(pos, kind, dig);
    @(posedge clk); #1;
    check(pos == 6, req);
    if (pos == 6) pos = 0;
    for (int i = 1; i < hold; i++) begin
      @(posedge clk); #1;
      check(1'b0, req);
    end
    @(negedge clk);
    digit_i = '0; start_i = 0; open_i = 0; any_i = 0;
    for (int i = 0; i < gap; i++) begin
      @(posedge clk); #1;
      check(1'b0, req);
    end
  endtask

  task automatic enter_code(string req);
    press(K_START, 0, 1, 1, req);
    for (int i = 0; i < 4; i++) press(K_DIG, code_at(i), 1, 1, req);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; digit_i = '0; start_i = 0; open_i = 0; any_i = 0;
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1 in reset");
    @(negedge clk) rst_n = 1;
    repeat (5) @(posedge clk);
    #1 check(1'b0, "R1 after reset");

    // R1 / R8: digits and open with no start
    for (int i = 0; i < 4; i++) press(K_DIG, code_at(i), 1, 1, "R8 idle digit");
    press(K_OPEN, 0, 1, 1, "R1 no start");

    // R3: basic unlock, short and long holds
    enter_code("R3 basic");
    press(K_OPEN, 0, 1, 2, "R3 unlock");
    press(K_START, 0, 3, 2, "R3 seq2");
    for (int i = 0; i < 4; i++) press(K_DIG, code_at(i), 4, 3, "R3 held");
    press(K_OPEN, 0, 5, 2, "R3 unlock held");

    // R2: long hold counts once
    press(K_START, 0, 1, 1, "R2");
    press(K_DIG, C0, 20, 1, "R2 long hold");
    press(K_DIG, C1, 1, 1, "R2");
    press(K_DIG, C2, 1, 1, "R2");
    press(K_DIG, C3, 1, 1, "R2");
    press(K_OPEN, 0, 1, 1, "R2 unlock after hold");

    // R2: line switched under held any_i is not taken
    enter_code("R2 switch");
    @(negedge clk); digit_i = '0; digit_i[C0] = 1; any_i = 1;
    pos = model_next(pos, K_DIG, C0);
    @(posedge clk); #1 check(1'b0, "R2 switch");
    @(negedge clk); digit_i = '0; open_i = 1;
    @(posedge clk); #1 check(1'b0, "R2 switched line ignored");
    @(negedge clk); open_i = 0; any_i = 0;
    @(posedge clk); #1 check(1'b0, "R2 switch");
    press(K_OPEN, 0, 1, 1, "R2 switch open");

    // R4: wrong digit then rest
    press(K_START, 0, 1, 1, "R4");
    press(K_DIG, C0, 1, 1, "R4");
    press(K_DIG, (C1 + 1) % 10, 1, 1, "R4 wrong");
    press(K_DIG, C2, 1, 1, "R4");
    press(K_DIG, C3, 1, 1, "R4");
    press(K_OPEN, 0, 1, 1, "R4 no unlock");

    // R5: early open
    press(K_START, 0, 1, 1, "R5");
    press(K_DIG, C0, 1, 1, "R5");
    press(K_DIG, C1, 1, 1, "R5");
    press(K_OPEN, 0, 1, 1, "R5 early open");
    press(K_DIG, C2, 1, 1, "R5");
    press(K_DIG, C3, 1, 1, "R5");
    press(K_OPEN, 0, 1, 1, "R5 no unlock");

    // R6: extra digit
    enter_code("R6");
    press(K_DIG, 0, 1, 1, "R6 extra digit");
    press(K_OPEN, 0, 1, 1, "R6 no unlock");

    // R7: restart mid-attempt
    press(K_START, 0, 1, 1, "R7");
    press(K_DIG, C0, 1, 1, "R7");
    press(K_DIG, C1, 1, 1, "R7");
    enter_code("R7 restart");
    press(K_OPEN, 0, 1, 1, "R7 unlock after restart");

    // R9: empty press mid-attempt
    press(K_START, 0, 1, 1, "R9");
    press(K_DIG, C0, 1, 1, "R9");
    press(K_NONE, 0, 2, 1, "R9 empty press");
    press(K_DIG, C1, 1, 1, "R9");
    press(K_DIG, C2, 1, 1, "R9");
    press(K_DIG, C3, 1, 1, "R9");
    press(K_OPEN, 0, 1, 1, "R9 unlock");

    // R10: digit bit positions, a neighbour bit does not match
    press(K_START, 0, 1, 1, "R10");
    press(K_DIG, C0 + 1, 1, 1, "R10 neighbour bit");
    for (int i = 1; i < 4; i++) press(K_DIG, code_at(i), 1, 1, "R10");
    press(K_OPEN, 0, 1, 1, "R10 no unlock");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sc = $urandom_range(0, 2);
      if (sc == 2) begin
        press($urandom_range(0, 3), $urandom_range(0, 9),
              $urandom_range(1, 4), $urandom_range(1, 3), "R3 random key");
      end else begin
        int bad = (sc == 1) ? $urandom_range(0, 5) : 9;
        for (int s = 0; s < 6; s++) begin
          int k = (s == 0) ? K_START : (s == 5) ? K_OPEN : K_DIG;
          int d = (s >= 1 && s <= 4) ? code_at(s - 1) : 0;
          if (s == bad) begin
            k = $urandom_range(0, 3);
            d = $urandom_range(0, 9);
          end
          press(k, d, $urandom_range(1, 4), $urandom_range(1, 3), "R3 random seq");
        end
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule